// File: doc/BRIEF.md
# Two-List Second-Chance Page Manager

This block tracks which pages occupy a small pool of physical slots and decides, on every access, whether the access can go ahead at full speed or must be handled as a fault. The slots are split into two ordered lists. The first is the active list. Its pages are mapped read-write, and it is kept in arrival order: the newest page sits at the head and the oldest at the tail. The second list holds pages that have been demoted and are marked inaccessible. It is kept in recency order, with the most recently demoted page at its head.

Each cycle the client may present one page tag. The tag is compared against every occupied slot of both lists at once. One cycle later a strobe reports the outcome:
- **Active hit.** Nothing moves.
- **Second-list hit.** The page is promoted to the head of the active list, and the oldest active page drops to the head of the second list if the active list is full.
- **Miss.** The page enters at the head of the active list, and the tail of the second list is reported as the victim once both lists are full.

A separate lookup port reports, combinationally, where any tag currently lives and whether it is accessible. The block holds only membership, order and access marking. Moving page data and storing translations are left to the surrounding system.

Top module: `page_two_list`

## Requirements
- R1: One cycle after a request, `done` is 1 and exactly one of `hit_active`, `hit_second`, `miss` is 1. In a cycle that follows no request, `done`, the three outcome flags and `evict_valid` are all 0.
- R2: A request whose tag is in the active list reports `hit_active`. It changes neither list's contents or order and evicts nothing.
- R3: A request whose tag is in the second list reports `hit_second`. The tag leaves the second list and becomes the head of the active list (read-write). If the active list was full, its tail moves to the head of the second list. No eviction is reported.
- R4: A request whose tag is in neither list reports `miss`, and the tag becomes the head of the active list. If both lists are full, the active tail moves to the second-list head, and the second-list tail is reported on `evict_tag` with `evict_valid` = 1.
- R5: While the active list has a free slot, a miss only fills it. While the active list is full but the second list has room, a miss demotes the active tail into the second list. Neither case reports an eviction.
- R6: With `SC_N` = 0 the block is a pure FIFO. A miss with a full active list evicts the active tail directly.
- R7: `q_loc` encodes the location of `q_tag`: 2'b01 means active list, 2'b10 means second list, 2'b00 means absent. `q_rw` is 1 only for 2'b01.
- R8: After reset both lists are empty: every tag reads `q_loc` = 2'b00, and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_tag | input | TAG_W | Page tag of the request |
| done | output | 1 | Outcome strobe, one cycle after a request |
| hit_active | output | 1 | Outcome: tag was in the active list |
| hit_second | output | 1 | Outcome: tag was in the second list |
| miss | output | 1 | Outcome: tag was in neither list |
| evict_valid | output | 1 | A victim page left the pool |
| evict_tag | output | TAG_W | Tag of the victim page |
| q_tag | input | TAG_W | Tag to look up |
| q_loc | output | 2 | Location code of q_tag |
| q_rw | output | 1 | q_tag is mapped read-write |

## Verification
The hardest situation to reach is a second-list hit while the active list is full. In that case a removal from the middle of the second list and an insertion at its head happen in the same cycle. This needs both lists to be full and a tag that was demoted but not yet evicted.

A directed prologue fills the active list, pushes two pages into the second list, and then requests one of them. A long random phase follows, using a tag range only slightly larger than the pool, so that all three outcomes recur with both lists full. A second instance with an empty second list runs the same stimulus to exercise the pure FIFO variant.

// File: rtl/page_two_list_pkg.sv
package page_two_list_pkg;
  typedef enum logic [1:0] {
    LOC_NONE   = 2'b00,
    LOC_ACTIVE = 2'b01,
    LOC_SECOND = 2'b10
  } loc_e;

  function automatic logic [1:0] loc_code(input logic in_act, input logic in_sec);
    if (in_act)      return LOC_ACTIVE;
    else if (in_sec) return LOC_SECOND;
    else             return LOC_NONE;
  endfunction
endpackage

// File: rtl/page_two_list_cam.sv
module page_two_list_cam #(
  parameter int N     = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 3,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0][TAG_W-1:0] ent,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [TAG_W-1:0]        tag,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if ((CNT_W'(i) < cnt) && (ent[i] == tag)) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/page_two_list.sv
module page_two_list
  import page_two_list_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int ACT_N = 4,
  parameter int SC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  output logic             done,
  output logic             hit_active,
  output logic             hit_second,
  output logic             miss,
  output logic             evict_valid,
  output logic [TAG_W-1:0] evict_tag,
  input  logic [TAG_W-1:0] q_tag,
  output logic [1:0]       q_loc,
  output logic             q_rw
);
  localparam int SC_D  = (SC_N > 0) ? SC_N : 1;
  localparam int AC_W  = $clog2(ACT_N + 1);
  localparam int SC_W  = $clog2(SC_D + 1);
  localparam int AI_W  = (ACT_N > 1) ? $clog2(ACT_N) : 1;
  localparam int SI_W  = (SC_D > 1) ? $clog2(SC_D) : 1;

  logic [ACT_N-1:0][TAG_W-1:0] act_q, act_d;
  logic [SC_D-1:0][TAG_W-1:0]  sc_q, sc_d;
  logic [AC_W-1:0]             acnt_q, acnt_d;
  logic [SC_W-1:0]             scnt_q, scnt_d;

  // named internal events
  logic             a_hit, s_hit, qa_hit, qs_hit;
  logic [AI_W-1:0]  a_idx, qa_idx;
  logic [SI_W-1:0]  s_idx, qs_idx;
  logic             a_full, s_full, fault, ev_d;
  logic [TAG_W-1:0] ovf_tag, evt_d;

  assign a_full  = (acnt_q == AC_W'(ACT_N));
  assign s_full  = (scnt_q == SC_W'(SC_N));
  assign fault   = req_valid && !a_hit;
  assign ovf_tag = act_q[ACT_N-1];

  page_two_list_cam #(.N(ACT_N), .TAG_W(TAG_W), .CNT_W(AC_W), .IDX_W(AI_W)) u_cam_act (
    .ent(act_q), .cnt(acnt_q), .tag(req_tag), .hit(a_hit), .idx(a_idx));
  page_two_list_cam #(.N(ACT_N), .TAG_W(TAG_W), .CNT_W(AC_W), .IDX_W(AI_W)) u_cam_qact (
    .ent(act_q), .cnt(acnt_q), .tag(q_tag), .hit(qa_hit), .idx(qa_idx));

  generate
    if (SC_N > 0) begin : g_second
      page_two_list_cam #(.N(SC_D), .TAG_W(TAG_W), .CNT_W(SC_W), .IDX_W(SI_W)) u_cam_sec (
        .ent(sc_q), .cnt(scnt_q), .tag(req_tag), .hit(s_hit), .idx(s_idx));
      page_two_list_cam #(.N(SC_D), .TAG_W(TAG_W), .CNT_W(SC_W), .IDX_W(SI_W)) u_cam_qsec (
        .ent(sc_q), .cnt(scnt_q), .tag(q_tag), .hit(qs_hit), .idx(qs_idx));
    end else begin : g_fifo_only
      assign s_hit  = 1'b0;
      assign s_idx  = '0;
      assign qs_hit = 1'b0;
      assign qs_idx = '0;
    end
  endgenerate

  assign q_loc = loc_code(qa_hit, qs_hit);
  assign q_rw  = qa_hit;

  always_comb begin
    act_d  = act_q;
    sc_d   = sc_q;
    acnt_d = acnt_q;
    scnt_d = scnt_q;
    ev_d   = 1'b0;
    evt_d  = '0;
    if (fault) begin
      if (s_hit) begin
        // pull the page out of the second list
        for (int i = 0; i < SC_D - 1; i++)
          if (i >= int'(s_idx)) sc_d[i] = sc_q[i + 1];
        scnt_d = scnt_q - 1'b1;
        if (a_full) begin
          for (int i = SC_D - 1; i >= 1; i--) sc_d[i] = sc_d[i - 1];
          sc_d[0] = ovf_tag;
          scnt_d  = scnt_q;
        end else begin
          acnt_d = acnt_q + 1'b1;
        end
      end else if (!a_full) begin
        acnt_d = acnt_q + 1'b1;
      end else if (SC_N == 0) begin
        ev_d  = 1'b1;
        evt_d = ovf_tag;
      end else begin
        if (s_full) begin
          ev_d  = 1'b1;
          evt_d = sc_q[SC_D-1];
        end else begin
          scnt_d = scnt_q + 1'b1;
        end
        for (int i = SC_D - 1; i >= 1; i--) sc_d[i] = sc_q[i - 1];
        sc_d[0] = ovf_tag;
      end
      for (int i = ACT_N - 1; i >= 1; i--) act_d[i] = act_q[i - 1];
      act_d[0] = req_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q       <= '0;
      sc_q        <= '0;
      acnt_q      <= '0;
      scnt_q      <= '0;
      done        <= 1'b0;
      hit_active  <= 1'b0;
      hit_second  <= 1'b0;
      miss        <= 1'b0;
      evict_valid <= 1'b0;
      evict_tag   <= '0;
    end else begin
      act_q       <= act_d;
      sc_q        <= sc_d;
      acnt_q      <= acnt_d;
      scnt_q      <= scnt_d;
      done        <= req_valid;
      hit_active  <= req_valid && a_hit;
      hit_second  <= fault && s_hit;
      miss        <= fault && !s_hit;
      evict_valid <= ev_d;
      evict_tag   <= evt_d;
    end
  end

  // ---------------- assertions ----------------
  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({hit_active, hit_second, miss}) == 1));
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(hit_active || hit_second || miss || evict_valid));
  assert_active_hit_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_active |-> (act_q == $past(act_q)) && (acnt_q == $past(acnt_q))
                   && (scnt_q == $past(scnt_q)) && !evict_valid);
  assert_second_hit_no_evict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_second |-> !evict_valid && (act_q[0] == $past(req_tag)));
  assert_miss_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (act_q[0] == $past(req_tag)));
  assert_evict_only_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> miss && $past(a_full) && $past(s_full));
  assert_count_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acnt_q <= AC_W'(ACT_N)) && (scnt_q <= SC_W'(SC_N)));
  assert_query_rw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_rw |-> (q_loc == 2'b01));
endmodule

// File: tb/page_two_list_tb.sv
module page_two_list_tb;
  localparam int TAG_W = 8;
  localparam int ACT_N = 4;
  localparam int SC_N  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [TAG_W-1:0] q_tag = '0;

  logic done0, ha0, hs0, ms0, ev0, qrw0;
  logic [TAG_W-1:0] et0;
  logic [1:0] ql0;
  logic done1, ha1, hs1, ms1, ev1, qrw1;
  logic [TAG_W-1:0] et1;
  logic [1:0] ql1;

  always #10 clk = ~clk;

  page_two_list #(.TAG_W(TAG_W), .ACT_N(ACT_N), .SC_N(SC_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .done(done0), .hit_active(ha0), .hit_second(hs0), .miss(ms0),
    .evict_valid(ev0), .evict_tag(et0), .q_tag(q_tag), .q_loc(ql0), .q_rw(qrw0));

  page_two_list #(.TAG_W(TAG_W), .ACT_N(ACT_N), .SC_N(0)) u_dut_fifo (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .done(done1), .hit_active(ha1), .hit_second(hs1), .miss(ms1),
    .evict_valid(ev1), .evict_tag(et1), .q_tag(q_tag), .q_loc(ql1), .q_rw(qrw1));

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [TAG_W-1:0] aq0[$], sq0[$], aq1[$], sq1[$];
  bit x_req;
  bit x_ha[2], x_hs[2], x_ms[2], x_ev[2];
  logic [TAG_W-1:0] x_et[2];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference policy on queues: index 0 = head
  task automatic model_step(input int which, input logic [TAG_W-1:0] t);
    logic [TAG_W-1:0] aq[$], sq[$], ov;
    int sn, k;
    sn = (which == 0) ? SC_N : 0;
    aq = (which == 0) ? aq0 : aq1;
    sq = (which == 0) ? sq0 : sq1;
    x_ha[which] = 0; x_hs[which] = 0; x_ms[which] = 0; x_ev[which] = 0; x_et[which] = '0;
    k = -1;
    foreach (aq[i]) if (aq[i] == t) k = i;
    if (k >= 0) begin
      x_ha[which] = 1;
    end else begin
      k = -1;
      foreach (sq[i]) if (sq[i] == t) k = i;
      if (k >= 0) begin
        x_hs[which] = 1;
        sq.delete(k);
        if (aq.size() == ACT_N) begin ov = aq.pop_back(); sq.push_front(ov); end
      end else begin
        x_ms[which] = 1;
        if (aq.size() == ACT_N) begin
          ov = aq.pop_back();
          if (sn == 0) begin
            x_ev[which] = 1; x_et[which] = ov;
          end else begin
            if (sq.size() == sn) begin x_ev[which] = 1; x_et[which] = sq.pop_back(); end
            sq.push_front(ov);
          end
        end
      end
      aq.push_front(t);
    end
    if (which == 0) begin aq0 = aq; sq0 = sq; end
    else begin aq1 = aq; sq1 = sq; end
  endtask

  function automatic int model_loc(input int which, input logic [TAG_W-1:0] t);
    logic [TAG_W-1:0] aq[$], sq[$];
    aq = (which == 0) ? aq0 : aq1;
    sq = (which == 0) ? sq0 : sq1;
    foreach (aq[i]) if (aq[i] == t) return 1;
    foreach (sq[i]) if (sq[i] == t) return 2;
    return 0;
  endfunction

  task automatic check_outputs();
    string rq;
    for (int w = 0; w < 2; w++) begin
      logic d, a, s, m, e;
      logic [TAG_W-1:0] et;
      d = (w == 0) ? done0 : done1;
      a = (w == 0) ? ha0 : ha1;
      s = (w == 0) ? hs0 : hs1;
      m = (w == 0) ? ms0 : ms1;
      e = (w == 0) ? ev0 : ev1;
      et = (w == 0) ? et0 : et1;
      if (!x_req) begin
        chk("R1", "idle strobe", int'({d, a, s, m, e}), 0);
      end else begin
        rq = x_ha[w] ? "R2" : (x_hs[w] ? "R3" : "R4");
        if (w == 1) rq = "R6";
        chk("R1", "done", int'(d), 1);
        chk(rq, "hit_active", int'(a), int'(x_ha[w]));
        chk(rq, "hit_second", int'(s), int'(x_hs[w]));
        chk(rq, "miss", int'(m), int'(x_ms[w]));
        chk(x_ev[w] ? rq : "R5", "evict_valid", int'(e), int'(x_ev[w]));
        if (x_ev[w]) chk(rq, "evict_tag", int'(et), int'(x_et[w]));
      end
    end
  endtask

  task automatic check_query(input logic [TAG_W-1:0] t);
    int l0, l1;
    q_tag = t;
    #1;
    l0 = model_loc(0, t);
    l1 = model_loc(1, t);
    chk("R7", "q_loc", int'(ql0), l0);
    chk("R7", "q_rw", int'(qrw0), int'(l0 == 1));
    chk("R6", "fifo q_loc", int'(ql1), l1);
  endtask

  task automatic cycle(input bit v, input logic [TAG_W-1:0] t);
    @(negedge clk);
    check_outputs();
    check_query(t);
    check_query(TAG_W'($urandom_range(0, 11)));
    x_req = v;
    if (v) begin model_step(0, t); model_step(1, t); end
    req_valid = v;
    req_tag = t;
  endtask

  initial begin
    x_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8: empty after reset
    chk("R8", "done after reset", int'(done0), 0);
    for (int t = 0; t < 12; t++) begin
      q_tag = TAG_W'(t);
      #1;
      chk("R8", "q_loc after reset", int'(ql0), 0);
    end
    // directed prologue: fill, demote, promote, evict, active hit
    cycle(1, 8'd1); cycle(1, 8'd2); cycle(1, 8'd3); cycle(1, 8'd4);
    cycle(1, 8'd5); cycle(1, 8'd6);
    cycle(1, 8'd1);
    cycle(1, 8'd7);
    cycle(1, 8'd6);
    cycle(0, 8'd0);
    cycle(1, 8'd3);
    for (int n = 0; n < 4000; n++)
      cycle(($urandom_range(0, 9) < 7), TAG_W'($urandom_range(0, 9)));
    cycle(0, 8'd0);
    cycle(0, 8'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule